// File: doc/BRIEF.md
# Bit-Addressable Parallel I/O Port

This block sits on a single-bit serial CPU I/O bus and gives the processor bit-level access to sixteen discrete input lines and sixteen latched output lines. One 4-bit bit address is shared by both directions. On a read it picks the input line to return. On a write it picks the output flip-flop that receives the data bit. An active-low module select enables the block. An active-low store strobe, qualified by that select, commits a write on the system clock.

Every bus line uses a fixed active-low convention. The write-data bit is inverted before it is stored. The read-data line is low when the CPU should see a logic 1, and a low level on a peripheral input reads as logic 1. Each output models an open-collector sink. A stored 1 drives the output-enable of an open-drain pin, which pulls the pin low. A stored 0 releases the pin.

Top module: `bit_pio`

## Requirements
- R1: While `rst` is high at a clock edge, all 16 output flip-flops clear, so `sink_en` reads 16'h0000 on the next cycle.
- R2: While `mod_sel_n` is 0, `rdata_n` equals `pin_in[bit_addr]` combinationally. A low pin (logic 1 to the CPU) gives a low `rdata_n`, and a high pin gives a high `rdata_n`.
- R3: While `mod_sel_n` is 1, `rdata_n` is 1 whatever the address and pins are.
- R4: A clock edge with `mod_sel_n`=0 and `store_n`=0 stores `~wdata_n` into flip-flop `bit_addr`. The result shows on `sink_en[bit_addr]` from the next cycle, where 1 means the pin sinks and 0 means it is released.
- R5: A clock edge with `mod_sel_n`=1 leaves `sink_en` unchanged, even when `store_n` is 0.
- R6: A clock edge with `store_n`=1 leaves `sink_en` unchanged, even when `mod_sel_n` is 0.
- R7: A write changes at most the addressed bit of `sink_en`. The other 15 bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel_n | input | 1 | Module select, active low |
| store_n | input | 1 | Write strobe, active low |
| bit_addr | input | 4 | Shared bit address |
| wdata_n | input | 1 | Write data bit, active low |
| pin_in | input | 16 | Peripheral input levels (1 = high voltage) |
| rdata_n | output | 1 | Read data bit, active low |
| sink_en | output | 16 | Open-drain enables (1 = pull pin low) |

## Verification
The hardest case to reach from the ports is a pair of consecutive writes to one address with opposite data, while the other fifteen bits hold a mixed pattern. Reaching it this way shows that a write overwrites its own bit and leaves its neighbours alone. The stimulus first fills the latch with random writes. It then sends a directed write-then-clear pair to the top and bottom addresses. Random cycles also keep one of the two strobes inactive on some cycles, so that single-strobe edges occur often and can be seen to leave the outputs unchanged.

// File: rtl/bit_pio_pkg.sv
package bit_pio_pkg;
    localparam int unsigned LINES = 16;
    localparam int unsigned AW    = $clog2(LINES);

    typedef logic [AW-1:0]    addr_t;
    typedef logic [LINES-1:0] line_vec_t;

    // Bus request translated to active-high internal polarity
    typedef struct packed {
        logic  selected;
        logic  commit;
        addr_t addr;
        logic  data;
    } bus_req_t;

    function automatic bus_req_t decode_bus(input logic sel_n, input logic stb_n,
                                            input addr_t a, input logic d_n);
        bus_req_t r;
        r.selected = ~sel_n;
        r.commit   = ~sel_n & ~stb_n;
        r.addr     = a;
        r.data     = ~d_n;
        return r;
    endfunction
endpackage

// File: rtl/bit_pio_rd_sel.sv
module bit_pio_rd_sel #(
    parameter int unsigned N  = 16,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          selected,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  pins,
    output logic          rd_n
);
    logic level_logic;

    always_comb begin
        // low voltage on a pin means logic 1 to the processor
        level_logic = ~pins[addr];
        rd_n        = selected ? ~level_logic : 1'b1;
    end
endmodule

// File: rtl/bit_pio_wr_dec.sv
module bit_pio_wr_dec #(
    parameter int unsigned N  = 16,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          en,
    input  logic [AW-1:0] addr,
    output logic [N-1:0]  wen
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        assign wen[i] = en && (addr == AW'(i));
    end
endmodule

// File: rtl/bit_pio_latch.sv
module bit_pio_latch #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] wen,
    input  logic         d,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (wen[i])
                q[i] <= d;
        end
    end
endmodule

// File: rtl/bit_pio.sv
module bit_pio
    import bit_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mod_sel_n,
    input  logic        store_n,
    input  logic [3:0]  bit_addr,
    input  logic        wdata_n,
    input  logic [15:0] pin_in,
    output logic        rdata_n,
    output logic [15:0] sink_en
);
    bus_req_t  req;
    line_vec_t wen;

    always_comb req = decode_bus(mod_sel_n, store_n, bit_addr, wdata_n);

    bit_pio_rd_sel #(.N(LINES)) u_rd (
        .selected (req.selected),
        .addr     (req.addr),
        .pins     (pin_in),
        .rd_n     (rdata_n)
    );

    bit_pio_wr_dec #(.N(LINES)) u_dec (
        .en   (req.commit),
        .addr (req.addr),
        .wen  (wen)
    );

    bit_pio_latch #(.N(LINES)) u_lat (
        .clk (clk),
        .rst (rst),
        .wen (wen),
        .d   (req.data),
        .q   (sink_en)
    );
endmodule

// File: rtl/bit_pio_chk.sv
module bit_pio_chk (
    input logic        clk,
    input logic        rst,
    input logic        mod_sel_n,
    input logic        store_n,
    input logic [3:0]  bit_addr,
    input logic        wdata_n,
    input logic [15:0] pin_in,
    input logic        rdata_n,
    input logic [15:0] sink_en
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> sink_en == 16'h0000);

    // R2
    read_path_chk: assert property (@(posedge clk) disable iff (rst)
        !mod_sel_n |-> rdata_n == pin_in[bit_addr]);

    // R3
    desel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        mod_sel_n |-> rdata_n);

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (!mod_sel_n && !store_n) |=> sink_en[$past(bit_addr)] == !$past(wdata_n));

    // R5
    desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mod_sel_n |=> $stable(sink_en));

    // R6
    no_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        store_n |=> $stable(sink_en));

    // R7
    single_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (!mod_sel_n && !store_n) |=> $countones(sink_en ^ $past(sink_en)) <= 1);
endmodule

bind bit_pio bit_pio_chk u_chk (.*);

// File: tb/test_bit_pio.sv
`timescale 1ns/1ps
module test_bit_pio;
    logic        clk = 1'b0;
    logic        rst;
    logic        mod_sel_n, store_n, wdata_n;
    logic [3:0]  bit_addr;
    logic [15:0] pin_in;
    logic        rdata_n;
    logic [15:0] sink_en;

    int checks = 0;
    int errors = 0;
    logic [15:0] model;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bit_pio i_bit_pio (.*);

    task automatic check(input bit ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic exp_rd(input logic s_n, input logic [3:0] a,
                                    input logic [15:0] p);
        return s_n ? 1'b1 : p[a];
    endfunction

    // Drive one cycle at negedge, check read, then check latch one cycle later
    task automatic apply(input logic s_n, input logic st_n, input logic [3:0] a,
                         input logic d_n, input logic [15:0] p);
        logic er;
        string tag;
        mod_sel_n = s_n; store_n = st_n; bit_addr = a; wdata_n = d_n; pin_in = p;
        #1;
        er = exp_rd(s_n, a, p);
        check(rdata_n === er, s_n ? "R3" : "R2", {15'b0, rdata_n}, {15'b0, er});
        @(negedge clk);
        if (!s_n && !st_n) begin
            model[a] = ~d_n;
            tag = "R4/R7";
        end else if (s_n) begin
            tag = "R5";
        end else begin
            tag = "R6";
        end
        check(sink_en === model, tag, sink_en, model);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1'b1; mod_sel_n = 1'b1; store_n = 1'b1; wdata_n = 1'b1;
        bit_addr = '0; pin_in = 16'hA5C3; model = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(sink_en === 16'h0, "R1", sink_en, 16'h0);
        rst = 1'b0;

        // directed corners
        apply(1'b0, 1'b0, 4'd0,  1'b0, 16'h0000);   // R4 set bit 0, read low pin
        apply(1'b0, 1'b0, 4'd15, 1'b0, 16'hFFFF);   // R4 set bit 15, read high pin
        apply(1'b0, 1'b0, 4'd15, 1'b1, 16'h7FFF);   // R4 clear bit 15
        apply(1'b1, 1'b0, 4'd3,  1'b0, 16'h0000);   // R5 strobe without select
        apply(1'b0, 1'b1, 4'd3,  1'b0, 16'h0008);   // R6 select without strobe
        apply(1'b1, 1'b1, 4'd7,  1'b0, 16'h0000);   // R3 deselected read

        // random fill and mixing
        for (int i = 0; i < 400; i++) begin
            apply(($urandom % 4) == 0, ($urandom % 3) == 0, 4'($urandom),
                  1'($urandom), 16'($urandom));
        end

        // write then clear the same bit on a mixed pattern, both ends
        apply(1'b0, 1'b0, 4'd0,  1'b0, 16'h1234);
        apply(1'b0, 1'b0, 4'd0,  1'b1, 16'h1234);
        apply(1'b0, 1'b0, 4'd15, 1'b0, 16'h8001);
        apply(1'b0, 1'b0, 4'd15, 1'b1, 16'h8001);

        // reset mid-run clears latched outputs
        apply(1'b0, 1'b0, 4'd5, 1'b0, 16'h0);
        rst = 1'b1;
        @(negedge clk);
        model = '0;
        check(sink_en === 16'h0, "R1", sink_en, 16'h0);
        rst = 1'b0;
        apply(1'b0, 1'b0, 4'd9, 1'b0, 16'h0200);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule